// File: doc/BRIEF.md
# Hamming-Protected Four-Channel Sequence Generator Array

This block holds four identical 10-stage maximal-length shift-register generators, each using the feedback stage 1 <= stage 3 XOR stage 10, and guards their 40 state bits against single upsets. Three extra parity generators run with the same feedback. Because the update is linear, the seven registers sharing one stage position always form a (7,4) Hamming codeword. No re-encoding is needed after reload. A syndrome decoder on each protected column flips the one bad bit before the next shift.

A parameter selects the decoder layout. In the full layout, every column is decoded each cycle and the outputs are always clean under single upsets. In the single-column layout, only one stage position (by default the feedback tap) is decoded. Shifting carries any error through that position within one register length, so the logic is about a tenth of the full layout at the cost of short output glitches.

The surrounding receiver pulses the reload input once per code period (every 1023 cycles) to return all generators to all ones. The flip input inverts chosen flip-flops. It serves for upset injection in test.

Top module: `hamlfsr_array`

## Requirements
- R1: An active reset or a reload pulse sets all 70 flip-flops to one at the next edge. Any flip request in the reload cycle is ignored, so the next cycle shows seq_bits = 4'b1111, fix_strobe = 0 and fail_strobe = 0.
- R2: Each row advances on every edge without reload: new stage 1 = stage 3 XOR stage 10, and new stage k = stage k-1 for k = 2..10. seq_bits[i] is the corrected stage 10 of data row i. From all ones, each data row then produces the period-1023 sequence.
- R3: Rows 0..3 are data rows d1..d4 and rows 4, 5, 6 are parity rows holding d1^d3^d4, d1^d2^d3 and d2^d3^d4 per column. With no flip requests, no column ever shows a nonzero syndrome, so fix_strobe stays 0.
- R4: flip[r*10 + s - 1] inverts stage s of row r at the edge (r = 0..6, s = 1..10), on top of the normal update.
- R5: In the full layout, a column holding exactly one wrong bit is corrected combinationally. Its syndrome (c5^d1^d3^d4, c6^d1^d2^d3, c7^d2^d3^d4) selects the bit to invert. fix_strobe is high, seq_bits equal the error-free value in that same cycle, and the stored state is clean after the next edge.
- R6: In the single-column layout, only stage 3 is decoded. A single injected error is detected (fix_strobe high in at least one cycle) and removed within 12 cycles. After that, seq_bits again match the error-free sequence.
- R7: fail_strobe is high in the cycle after a non-reload edge at which the flip request hit two or more flip-flops of the same stage position. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads all ones |
| reload | input | 1 | Synchronous reload of all generators to all ones |
| flip | input | 70 | Per-flip-flop inversion request, index row*10 + stage - 1 |
| seq_bits | output | 4 | Corrected stage-10 output of each data generator |
| fix_strobe | output | 1 | A decoded column has a nonzero syndrome this cycle |
| fail_strobe | output | 1 | Previous edge planted two or more errors in one column |

## Verification
An uncorrected bit in a data row reaches seq_bits within ten cycles as a flipped output bit. In the full layout, the wrong output appears in the very cycle the error is stored. A wrong parity row or a broken syndrome map shows up as a missing fix_strobe one cycle after a single flip, or as a seq_bits mismatch against the plain reference sequence. In the single-column layout, a decoder placed at the wrong stage leaves a glitch that outlasts the 12-cycle recovery window, and the window-end comparison catches it.

// File: rtl/hamlfsr_pkg.sv
package hamlfsr_pkg;

   localparam int DATA_ROWS = 4;
   localparam int PAR_ROWS  = 3;
   localparam int ROWS      = DATA_ROWS + PAR_ROWS;
   localparam int SYN_W     = 3;

   // word bits 0..3 are data rows, 4..6 are the parity rows
   function automatic logic [SYN_W-1:0] col_syndrome(input logic [ROWS-1:0] w);
      logic [SYN_W-1:0] s;
      s[0] = w[4] ^ w[0] ^ w[2] ^ w[3];
      s[1] = w[5] ^ w[0] ^ w[1] ^ w[2];
      s[2] = w[6] ^ w[1] ^ w[2] ^ w[3];
      return s;
   endfunction

   function automatic logic [ROWS-1:0] syndrome_mask(input logic [SYN_W-1:0] s);
      logic [ROWS-1:0] m;
      case (s)
         3'b011:  m = 7'b000_0001;
         3'b110:  m = 7'b000_0010;
         3'b111:  m = 7'b000_0100;
         3'b101:  m = 7'b000_1000;
         3'b001:  m = 7'b001_0000;
         3'b010:  m = 7'b010_0000;
         3'b100:  m = 7'b100_0000;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/hamlfsr_col_dec.sv
module hamlfsr_col_dec
   import hamlfsr_pkg::*;
#(
   parameter bit ENABLE = 1'b1
)(
   input  logic [ROWS-1:0] word_i,
   output logic [ROWS-1:0] word_o,
   output logic            err_o
);

   logic [SYN_W-1:0] syn;

   assign syn   = col_syndrome(word_i);
   assign err_o = |syn;

   generate
      if (ENABLE) begin : g_fix
         assign word_o = word_i ^ syndrome_mask(syn);
      end else begin : g_pass
         assign word_o = word_i;
      end
   endgenerate

endmodule

// File: rtl/hamlfsr_row_step.sv
module hamlfsr_row_step #(
   parameter int STAGES = 10,
   parameter int TAP    = 3
)(
   input  logic [STAGES-1:0] cur_i,
   output logic [STAGES-1:0] nxt_o
);

   generate
      if (STAGES < 3) begin : g_bad_len
         $error("hamlfsr_row_step: STAGES must be at least 3");
      end
      if (TAP < 1 || TAP >= STAGES) begin : g_bad_tap
         $error("hamlfsr_row_step: TAP must lie in 1..STAGES-1");
      end
   endgenerate

   // bit k-1 holds stage k
   assign nxt_o = {cur_i[STAGES-2:0], cur_i[TAP-1] ^ cur_i[STAGES-1]};

endmodule

// File: rtl/hamlfsr_hit_mon.sv
module hamlfsr_hit_mon
   import hamlfsr_pkg::*;
#(
   parameter int STAGES = 10,
   localparam int NFF   = ROWS * STAGES
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reload,
   input  logic [NFF-1:0] flip,
   output logic           fail_o
);

   logic [STAGES-1:0] multi_hit;

   generate
      for (genvar c = 0; c < STAGES; c++) begin : g_col
         logic [ROWS-1:0] hits;
         for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign hits[r] = flip[r*STAGES + c];
         end
         assign multi_hit[c] = ($countones(hits) > 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fail_o <= 1'b0;
      else        fail_o <= !reload && (|multi_hit);
   end

   // R7
   reload_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !fail_o);

endmodule

// File: rtl/hamlfsr_array.sv
module hamlfsr_array
   import hamlfsr_pkg::*;
#(
   parameter int STAGES      = 10,
   parameter int TAP         = 3,
   parameter bit FULL_DECODE = 1'b1,
   parameter int DEC_STAGE   = TAP,
   localparam int NFF        = ROWS * STAGES
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reload,
   input  logic [NFF-1:0]       flip,
   output logic [DATA_ROWS-1:0] seq_bits,
   output logic                 fix_strobe,
   output logic                 fail_strobe
);

   generate
      if (DEC_STAGE < 1 || DEC_STAGE > STAGES) begin : g_bad_dec
         $error("hamlfsr_array: DEC_STAGE must lie in 1..STAGES");
      end
   endgenerate

   logic [ROWS-1:0][STAGES-1:0] st_q;
   logic [ROWS-1:0][STAGES-1:0] st_fix;
   logic [ROWS-1:0][STAGES-1:0] st_nxt;
   logic [STAGES-1:0]           col_err;

   generate
      for (genvar c = 0; c < STAGES; c++) begin : g_col
         logic [ROWS-1:0] w_in;
         logic [ROWS-1:0] w_out;
         for (genvar r = 0; r < ROWS; r++) begin : g_bit
            assign w_in[r]      = st_q[r][c];
            assign st_fix[r][c] = w_out[r];
         end
         hamlfsr_col_dec #(
            .ENABLE(FULL_DECODE || (c == DEC_STAGE-1))
         ) u_dec (
            .word_i(w_in),
            .word_o(w_out),
            .err_o (col_err[c])
         );
      end

      for (genvar r = 0; r < ROWS; r++) begin : g_row
         hamlfsr_row_step #(.STAGES(STAGES), .TAP(TAP)) u_step (
            .cur_i(st_fix[r]),
            .nxt_o(st_nxt[r])
         );
      end

      for (genvar r = 0; r < DATA_ROWS; r++) begin : g_out
         assign seq_bits[r] = st_fix[r][STAGES-1];
      end

      if (FULL_DECODE) begin : g_full
         assign fix_strobe = |col_err;
      end else begin : g_one
         assign fix_strobe = col_err[DEC_STAGE-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= '1;
      else if (reload) st_q <= '1;
      else             st_q <= st_nxt ^ flip;
   end

   hamlfsr_hit_mon #(.STAGES(STAGES)) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .reload(reload),
      .flip  (flip),
      .fail_o(fail_strobe)
   );

   // R1
   reload_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (st_q == '1));

   // R3
   codeword_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && flip == '0 && col_err == '0) |=> (col_err == '0));

   generate
      if (FULL_DECODE) begin : g_full_chk
         // R5
         single_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!reload && $countones(flip) == 1 && col_err == '0) |=> fix_strobe);

         // R5
         repair_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!reload && flip == '0 && fix_strobe) |=> (col_err == '0));
      end
   endgenerate

endmodule

// File: tb/hamlfsr_array_test.sv
`timescale 1ns/1ps
module hamlfsr_array_test;

   localparam int S   = 10;
   localparam int NFF = 70;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reload = 1'b0;
   logic [NFF-1:0] flip = '0;
   logic [3:0]     seq_f, seq_c;
   logic           fix_f, fix_c, fail_f, fail_c;

   int nchk = 0;
   int nbad = 0;
   logic [S-1:0] ref_st;

   always #4 clk = ~clk;

   hamlfsr_array #(.FULL_DECODE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reload(reload), .flip(flip),
      .seq_bits(seq_f), .fix_strobe(fix_f), .fail_strobe(fail_f));

   hamlfsr_array #(.FULL_DECODE(1'b0)) uut_col (
      .clk(clk), .rst_n(rst_n), .reload(reload), .flip(flip),
      .seq_bits(seq_c), .fix_strobe(fix_c), .fail_strobe(fail_c));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_out();
      return {4{ref_st[S-1]}};
   endfunction

   // drive inputs at a falling edge, let one rising edge pass, land on the next falling edge
   task automatic cycle(input logic rl, input logic [NFF-1:0] fl);
      logic [S-1:0] nx;
      reload = rl;
      flip   = fl;
      nx = rl ? '1 : {ref_st[S-2:0], ref_st[2] ^ ref_st[S-1]};
      @(negedge clk);
      ref_st = nx;
      reload = 1'b0;
      flip   = '0;
   endtask

   initial begin
      #(8 * 150000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      logic seen_col;
      ref_st = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(seq_f == 4'hF, "R1 reset seq full", seq_f, 4'hF);
      chk(seq_c == 4'hF, "R1 reset seq onecol", seq_c, 4'hF);
      chk(!fix_f && !fix_c, "R1 reset fix", {fix_f, fix_c}, 0);
      chk(!fail_f && !fail_c, "R1 reset fail", {fail_f, fail_c}, 0);

      // exhaustive single-upset sweep: 3 passes over all 70 flip-flops
      for (int w = 0; w < 210; w++) begin
         int idx;
         idx = (w * 37) % NFF;
         cycle((w % 64) == 0, '0);
         chk(seq_f == ref_out(), "R2 seq full", seq_f, ref_out());
         chk(!fix_f, "R3 no syndrome when clean", fix_f, 0);
         cycle(1'b0, {{(NFF-1){1'b0}}, 1'b1} << idx);
         chk(fix_f, "R4/R5 fix strobe after single flip", fix_f, 1);
         chk(seq_f == ref_out(), "R5 corrected seq same cycle", seq_f, ref_out());
         seen_col = fix_c;
         for (int k = 2; k < 16; k++) begin
            cycle(1'b0, '0);
            chk(seq_f == ref_out(), "R5 seq full after repair", seq_f, ref_out());
            chk(!fix_f, "R5 state clean after repair", fix_f, 0);
            chk(!fail_f && !fail_c, "R7 no fail on single flip", {fail_f, fail_c}, 0);
            seen_col = seen_col | fix_c;
         end
         chk(seen_col, "R6 onecol detected single flip", seen_col, 1);
         chk(seq_c == ref_out(), "R6 onecol seq recovered", seq_c, ref_out());
         chk(!fix_c, "R6 onecol state clean", fix_c, 0);
      end

      // R1: reload with all flips requested
      cycle(1'b1, '1);
      chk(seq_f == 4'hF && seq_c == 4'hF, "R1 reload ignores flips", {seq_f, seq_c}, 8'hFF);
      chk(!fix_f && !fix_c, "R1 reload clean syndrome", {fix_f, fix_c}, 0);
      chk(!fail_f && !fail_c, "R1 reload masks fail", {fail_f, fail_c}, 0);
      for (int k = 0; k < 30; k++) begin
         cycle(1'b0, '0);
         chk(seq_f == ref_out(), "R2 seq full after reload", seq_f, ref_out());
         chk(seq_c == ref_out(), "R2 seq onecol after reload", seq_c, ref_out());
      end

      // R7 negative: two flips in different columns, still both corrected in full layout
      cycle(1'b0, (70'd1 << 4) | (70'd1 << 15));
      chk(!fail_f, "R7 split columns no fail", fail_f, 0);
      chk(fix_f, "R5 fix with two columns hit", fix_f, 1);
      chk(seq_f == ref_out(), "R5 two columns corrected", seq_f, ref_out());
      for (int k = 0; k < 14; k++) cycle(1'b0, '0);
      chk(seq_c == ref_out(), "R6 onecol two columns recovered", seq_c, ref_out());

      // R7: two flips in the same column (rows 0 and 1, stage 5)
      cycle(1'b0, (70'd1 << 4) | (70'd1 << 14));
      chk(fail_f && fail_c, "R7 double hit fail strobe", {fail_f, fail_c}, 3);
      cycle(1'b0, '0);
      chk(!fail_f && !fail_c, "R7 fail strobe one cycle", {fail_f, fail_c}, 0);
      cycle(1'b1, '0);
      chk(seq_f == 4'hF && seq_c == 4'hF, "R1 reload after double hit", {seq_f, seq_c}, 8'hFF);
      for (int k = 0; k < 20; k++) begin
         cycle(1'b0, '0);
         chk(seq_f == ref_out() && seq_c == ref_out(), "R2 seq after recovery reload",
             {seq_f, seq_c}, {ref_out(), ref_out()});
      end

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

endmodule